// File: doc/BRIEF.md
# Receive Non-Posted Hold Queue

This block sits in a receive packet path, between the transaction layer of a PCIe link and the application logic. It reads the header of every incoming packet and sorts it into one of three kinds: posted (memory writes and messages), non-posted (reads, I/O, configuration and atomic requests) or completion. Posted packets and completions share one queue. Non-posted packets have a queue of their own.

When the application raises `hold_np`, the block stops starting non-posted packets on its output. A small, bounded number of late deliveries is still allowed. Posted packets and completions keep flowing. Non-posted packets that are held wait in their queue and leave in arrival order once `hold_np` falls. None is ever dropped.

Both stream sides use valid/ready with start and end markers. A beat moves when valid and ready are both high at a rising clock edge. The input may stall a beat for any number of cycles. Once the output shows a beat, it keeps that beat unchanged until the application accepts it. `hold_np` is a plain level with no handshake and may change in any cycle.

Top module: `rx_np_hold`

## Requirements
- R1: The packet kind is decoded from the first beat only, using header byte `in_data[31:24]`. Its bits [4:0] are the Type field and bit 6 is the with-data flag of the Fmt field. The decode works as follows:
  - Type 0101x is a completion.
  - The following are non-posted: Type 00000 or 00001 with the flag clear, Type 00010, Type 0010x, and Type 01100, 01101 or 01110.
  - Every other code is posted.
  - Later beats of a packet follow the kind of its first beat.
- R2: Posted packets and completions are delivered while `hold_np` is high.
- R3: While `hold_np` is high, at most LATE_MAX non-posted packets start on the output. The allowance is restored in every cycle where `hold_np` is low. While allowance remains, queued non-posted packets keep flowing.
- R4: Held non-posted packets are released after `hold_np` falls. They leave in arrival order and none is lost.
- R5: Output packets are never interleaved: a new packet starts only after the previous end beat. Once `out_valid` is high, it and the beat stay unchanged until accepted.
- R6: Packets within one class (non-posted, or posted together with completions) keep their order. At a packet boundary, the posted/completion queue wins over the non-posted one.
- R7: `in_ready` is low only when the queue that the current beat targets is full. A beat offered to a full queue is held at the input, not lost.
- R8: Reset empties both queues, clears the late-delivery allowance and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_np | input | 1 | Application request to stop non-posted deliveries |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_data | input | DW | Input beat payload; header byte at [31:24] on first beat |
| in_sop | input | 1 | First beat of an input packet |
| in_eop | input | 1 | Last beat of an input packet |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Application takes the output beat |
| out_data | output | DW | Output beat payload |
| out_sop | output | 1 | First beat of an output packet |
| out_eop | output | 1 | Last beat of an output packet |

## Verification
The bench sweeps all 256 header byte values while the late allowance is used up. A wrong decode would either let a request through under the hold or strand a posted write. It queues a backlog of requests before raising the hold, so that an off-by-one allowance delivers two or four packets instead of exactly the limit. It mixes multi-beat packets of every class under a stalling consumer, so that mid-packet switching or reordering inside a class shows up as broken beat sequences. It also fills the request queue to the brim, and it resets with packets held and the allowance spent. A block that leaked stale packets or kept the old count would then deliver the wrong tags.

// File: rtl/rxnp_pkg.sv
package rxnp_pkg;

  typedef enum logic [1:0] {
    KIND_POSTED     = 2'd0,
    KIND_NONPOSTED  = 2'd1,
    KIND_COMPLETION = 2'd2
  } pkt_kind_e;

endpackage

// File: rtl/rxnp_classify.sv
module rxnp_classify
  import rxnp_pkg::*;
(
  input  logic [7:0] fmt_type,
  output pkt_kind_e  kind
);

  logic       has_data;
  logic [4:0] typ;

  assign has_data = fmt_type[6];
  assign typ      = fmt_type[4:0];

  always_comb begin
    kind = KIND_POSTED;
    if (typ[4:1] == 4'b0101)                                   kind = KIND_COMPLETION;
    else if ((typ == 5'b00000 || typ == 5'b00001) && !has_data) kind = KIND_NONPOSTED; // memory read
    else if (typ == 5'b00010)                                   kind = KIND_NONPOSTED; // I/O
    else if (typ[4:1] == 4'b0010)                               kind = KIND_NONPOSTED; // config
    else if (typ == 5'b01100 || typ == 5'b01101 || typ == 5'b01110)
                                                                kind = KIND_NONPOSTED; // atomics
  end

endmodule

// File: rtl/rxnp_fifo.sv
module rxnp_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign head  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the input side never writes a beat into a full queue
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < (AW+1)'(DEPTH)));

  // R4: the output side never takes a beat that is not stored
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/rxnp_arbiter.sv
module rxnp_arbiter #(
  parameter int W        = 34,
  parameter int LATE_MAX = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         pass_avail,
  input  logic [W-1:0] pass_head,
  input  logic         np_avail,
  input  logic [W-1:0] np_head,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_head,
  output logic         pass_pop,
  output logic         np_pop
);

  localparam int CW = $clog2(LATE_MAX + 1);

  logic          locked, lock_np, sel_np, np_ok, xfer, head_sop, head_eop;
  logic [CW-1:0] late_cnt;

  assign np_ok     = !hold || (late_cnt < CW'(LATE_MAX));
  assign sel_np    = locked ? lock_np : !pass_avail;
  assign out_valid = locked ? (lock_np ? np_avail : pass_avail)
                            : (pass_avail || (np_avail && np_ok));
  assign out_head  = sel_np ? np_head : pass_head;
  assign head_sop  = out_head[W-1];
  assign head_eop  = out_head[W-2];
  assign xfer      = out_valid && out_ready;
  assign np_pop    = xfer && sel_np;
  assign pass_pop  = xfer && !sel_np;

  // choice is frozen from the first offer until the end beat leaves
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      lock_np <= 1'b0;
    end else if (xfer && head_eop) begin
      locked  <= 1'b0;
    end else if (out_valid && !locked) begin
      locked  <= 1'b1;
      lock_np <= sel_np;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !hold)                                   late_cnt <= '0;
    else if (np_pop && head_sop && late_cnt < CW'(LATE_MAX)) late_cnt <= late_cnt + 1'b1;
  end

  // R3: a request starting under hold must still fit the allowance
  a_r3_late_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (np_pop && head_sop && hold) |-> (late_cnt < CW'(LATE_MAX)));

  // R5: an offered beat is neither withdrawn nor altered
  a_r5_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_head)));

  // R5: a fresh choice always lands on the first beat of a packet
  a_r5_boundary_sop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !locked) |-> head_sop);

endmodule

// File: rtl/rx_np_hold.sv
module rx_np_hold
  import rxnp_pkg::*;
#(
  parameter int DW         = 64,
  parameter int NP_DEPTH   = 16,
  parameter int PASS_DEPTH = 16,
  parameter int LATE_MAX   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_np,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop
);

  localparam int EW = DW + 2;
  localparam int HB = 24;

  pkt_kind_e     hdr_kind;
  logic          np_q, cur_np, accept;
  logic          np_push, pass_push, np_pop, pass_pop;
  logic          np_empty, np_full, pass_empty, pass_full;
  logic [EW-1:0] in_entry, np_head, pass_head, out_head;

  rxnp_classify u_cls (
    .fmt_type (in_data[HB+7:HB]),
    .kind     (hdr_kind)
  );

  assign cur_np    = in_sop ? (hdr_kind == KIND_NONPOSTED) : np_q;
  assign in_ready  = cur_np ? !np_full : !pass_full;
  assign accept    = in_valid && in_ready;
  assign np_push   = accept && cur_np;
  assign pass_push = accept && !cur_np;
  assign in_entry  = {in_sop, in_eop, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n)                np_q <= 1'b0;
    else if (accept && in_sop) np_q <= cur_np;
  end

  rxnp_fifo #(.W(EW), .DEPTH(NP_DEPTH)) u_np_q (
    .clk(clk), .rst_n(rst_n), .push(np_push), .wdata(in_entry),
    .pop(np_pop), .head(np_head), .empty(np_empty), .full(np_full)
  );

  rxnp_fifo #(.W(EW), .DEPTH(PASS_DEPTH)) u_pass_q (
    .clk(clk), .rst_n(rst_n), .push(pass_push), .wdata(in_entry),
    .pop(pass_pop), .head(pass_head), .empty(pass_empty), .full(pass_full)
  );

  rxnp_arbiter #(.W(EW), .LATE_MAX(LATE_MAX)) u_arb (
    .clk(clk), .rst_n(rst_n), .hold(hold_np),
    .pass_avail(!pass_empty), .pass_head(pass_head),
    .np_avail(!np_empty), .np_head(np_head),
    .out_ready(out_ready), .out_valid(out_valid), .out_head(out_head),
    .pass_pop(pass_pop), .np_pop(np_pop)
  );

  assign out_sop  = out_head[EW-1];
  assign out_eop  = out_head[EW-2];
  assign out_data = out_head[DW-1:0];

  // R7: back-pressure only ever comes from a full target queue
  a_r7_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (np_full || pass_full));

endmodule

// File: tb/test_rx_np_hold.sv
`timescale 1ns/1ps
module test_rx_np_hold;
  localparam int DW = 32, NPD = 8, PD = 4, LM = 3;

  logic clk = 0, rst_n = 0, hold = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0, slow = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;

  rx_np_hold #(.DW(DW), .NP_DEPTH(NPD), .PASS_DEPTH(PD), .LATE_MAX(LM)) i_rx_np_hold (
    .clk(clk), .rst_n(rst_n), .hold_np(hold),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, ntag = 0, npk = 0, cyc = 0;
  logic [7:0] t_hdr [1024];
  int t_len [1024];
  int pk_tag [1024];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] beat_word(input logic [7:0] h, input int tag, input int i);
    if (i == 0) return {h, 8'h00, 16'(tag)};
    return {8'hA5, 8'(i), 16'(tag)};
  endfunction

  // R1 decode from the requirement text
  function automatic bit exp_np(input logic [7:0] h);
    logic [4:0] t;
    t = h[4:0];
    if (t[4:1] == 4'b0101) return 0;
    if ((t == 5'd0 || t == 5'd1) && !h[6]) return 1;
    if (t == 5'b00010) return 1;
    if (t[4:1] == 4'b0010) return 1;
    if (t == 5'b01100 || t == 5'b01101 || t == 5'b01110) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (slow) out_ready <= (cyc % 3) != 0;
  end

  // output monitor: R5 beat sequencing and payload integrity
  bit open = 0;
  int cur = 0, idx = 0;
  always begin
    @(negedge clk); #5;
    if (!rst_n) open = 0;
    else if (out_valid && out_ready) begin
      if (!open) begin
        cur = int'(out_data[15:0]);
        chk(out_sop == 1'b1, "R5", "start beat flag", out_sop, 1);
        chk(out_data == beat_word(t_hdr[cur], cur, 0), "R5", "first beat word", out_data, beat_word(t_hdr[cur], cur, 0));
        chk(out_eop == (t_len[cur] == 1), "R5", "end flag on first beat", out_eop, t_len[cur] == 1);
        pk_tag[npk] = cur;
        npk++;
        idx = 1;
        open = !out_eop;
      end else begin
        chk(out_sop == 1'b0 && out_data == beat_word(t_hdr[cur], cur, idx), "R5", "continuation beat", out_data, beat_word(t_hdr[cur], cur, idx));
        chk(out_eop == (idx == t_len[cur] - 1), "R5", "end flag", out_eop, idx == t_len[cur] - 1);
        idx++;
        if (out_eop) open = 0;
      end
    end
  end

  task automatic send_beat(input logic [31:0] w, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1; in_data = w; in_sop = s; in_eop = e;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_pkt(input logic [7:0] h, input int len, output int tag);
    tag = ntag; t_hdr[tag] = h; t_len[tag] = len; ntag++;
    for (int i = 0; i < len; i++) send_beat(beat_word(h, tag, i), i == 0, i == len - 1);
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_hold(input bit v);
    @(negedge clk); hold = v;
  endtask

  // use up the allowance right after a fresh rise of the hold
  task automatic spend();
    int b, t;
    b = npk;
    for (int i = 0; i < LM; i++) send_pkt(8'h00, 1, t);
    wait_cyc(4);
    chk(npk == b + LM, "R3", "allowance delivered", npk - b, LM);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int b, t, nexp, cnt;
    int np_tags [8];
    int ps_tags [8];
    int qtag [9];

    // R8: reset state
    wait_cyc(3);
    #1;
    chk(out_valid == 0, "R8", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R8", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1; out_ready = 1;
    wait_cyc(2);

    // R1/R2/R4: sweep every header byte with the allowance spent
    set_hold(1);
    spend();
    for (int h = 0; h < 256; h++) begin
      b = npk;
      send_pkt(8'(h), 1, t);
      wait_cyc(4);
      if (exp_np(8'(h))) begin
        chk(npk == b, "R1", $sformatf("request 0x%02h held", h), npk - b, 0);
        set_hold(0);
        wait_cyc(4);
        chk(npk == b + 1 && pk_tag[b] == t, "R4", $sformatf("request 0x%02h released", h), npk - b, 1);
        set_hold(1);
        spend();
      end else begin
        chk(npk == b + 1 && pk_tag[b] == t, "R2", $sformatf("kind 0x%02h passes under hold", h), npk - b, 1);
      end
    end

    // R3: a backlog queued before the hold yields exactly LM deliveries
    set_hold(0);
    wait_cyc(4);
    @(negedge clk); out_ready = 0;
    send_pkt(8'h00, 1, qtag[0]);
    send_pkt(8'h02, 1, qtag[1]);
    send_pkt(8'h04, 1, qtag[2]);
    send_pkt(8'h4C, 1, qtag[3]);
    send_pkt(8'h01, 1, qtag[4]);
    b = npk;
    @(negedge clk); hold = 1; out_ready = 1;
    wait_cyc(8);
    chk(npk - b == LM, "R3", "late deliveries from backlog", npk - b, LM);
    for (int i = 0; i < LM; i++)
      chk(pk_tag[b + i] == qtag[i], "R4", "late delivery order", pk_tag[b + i], qtag[i]);
    send_pkt(8'h40, 1, t);
    wait_cyc(4);
    chk(npk - b == LM + 1 && pk_tag[b + LM] == t, "R2", "write overtakes held requests", npk - b, LM + 1);
    set_hold(0);
    wait_cyc(6);
    chk(npk - b == 6, "R4", "backlog fully released", npk - b, 6);
    chk(pk_tag[b + 4] == qtag[3] && pk_tag[b + 5] == qtag[4], "R4", "release order", pk_tag[b + 4], qtag[3]);

    // R6: mixed multi-beat traffic with a stalling consumer
    @(negedge clk); slow = 1;
    set_hold(1);
    b = npk;
    send_pkt(8'h00, 2, np_tags[0]);
    send_pkt(8'h60, 3, ps_tags[0]);
    send_pkt(8'h04, 1, np_tags[1]);
    send_pkt(8'h4A, 2, ps_tags[1]);
    send_pkt(8'h42, 3, np_tags[2]);
    send_pkt(8'h30, 1, ps_tags[2]);
    send_pkt(8'h4C, 2, np_tags[3]);
    wait_cyc(30);
    cnt = 0; nexp = 0;
    for (int i = b; i < npk; i++) begin
      if (exp_np(t_hdr[pk_tag[i]])) cnt++;
      else begin
        chk(pk_tag[i] == ps_tags[nexp], "R6", "posted/completion order", pk_tag[i], ps_tags[nexp]);
        nexp++;
      end
    end
    chk(cnt == LM, "R3", "requests under hold with mixed traffic", cnt, LM);
    chk(nexp == 3, "R2", "all posted/completions delivered", nexp, 3);
    set_hold(0);
    wait_cyc(20);
    nexp = 0;
    for (int i = b; i < npk; i++) begin
      if (exp_np(t_hdr[pk_tag[i]])) begin
        chk(pk_tag[i] == np_tags[nexp], "R6", "request order", pk_tag[i], np_tags[nexp]);
        nexp++;
      end
    end
    chk(nexp == 4, "R4", "requests all released", nexp, 4);
    @(negedge clk); slow = 0; out_ready = 1;
    wait_cyc(2);

    // R7: fill the request queue and stall the input
    set_hold(1);
    spend();
    b = npk;
    for (int i = 0; i < NPD; i++) send_pkt(8'h20, 1, qtag[i]);
    wait_cyc(4);
    chk(npk == b, "R3", "full queue held", npk - b, 0);
    t = ntag; t_hdr[t] = 8'h20; t_len[t] = 1; ntag++; qtag[NPD] = t;
    @(negedge clk);
    in_valid = 1; in_data = beat_word(8'h20, t, 0); in_sop = 1; in_eop = 1;
    #1;
    chk(in_ready == 0, "R7", "ready low on full queue", in_ready, 0);
    wait_cyc(3);
    #1;
    chk(in_ready == 0, "R7", "ready stays low", in_ready, 0);
    hold = 0;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
    wait_cyc(14);
    chk(npk - b == NPD + 1, "R4", "stalled beat not lost", npk - b, NPD + 1);
    for (int i = 0; i <= NPD; i++)
      chk(pk_tag[b + i] == qtag[i], "R4", "order after full", pk_tag[b + i], qtag[i]);

    // R8: reset with held packets and a spent allowance
    set_hold(1);
    spend();
    send_pkt(8'h00, 1, t);
    send_pkt(8'h00, 1, t);
    @(negedge clk); rst_n = 0;
    wait_cyc(3);
    #1;
    chk(out_valid == 0, "R8", "out_valid during reset", out_valid, 0);
    @(negedge clk); rst_n = 1;
    #1;
    chk(out_valid == 0, "R8", "queues empty after reset", out_valid, 0);
    chk(in_ready == 1, "R8", "ready after reset", in_ready, 1);
    b = npk;
    for (int i = 0; i < LM; i++) send_pkt(8'h04, 1, qtag[i]);
    wait_cyc(4);
    chk(npk - b == LM, "R8", "allowance restored by reset", npk - b, LM);
    for (int i = 0; i < LM; i++)
      chk(pk_tag[b + i] == qtag[i], "R8", "no stale request delivered", pk_tag[b + i], qtag[i]);
    send_pkt(8'h04, 1, t);
    wait_cyc(4);
    chk(npk - b == LM, "R3", "limit after reset", npk - b, LM);
    set_hold(0);
    wait_cyc(6);
    chk(npk - b == LM + 1 && pk_tag[npk - 1] == t, "R8", "only new request released", npk - b, LM + 1);

    finish_run();
  end
endmodule